// File: doc/BRIEF.md
# Asynchronous DMA Read Responder

This block answers the target side of a DMA read. It takes one data word at a time from a local source, raises an active-low request, and waits for an active-low acknowledge that the DMA master drives with no relation to the local clock. When the acknowledge is seen low, the block drives the held word onto a 16-bit bus and withdraws the request. It releases the bus at one of two points, chosen by how long the acknowledge stays low: a minimum number of clocks for a short pulse, or the synchronized return of the acknowledge for a long one.

A mode input enables this asynchronous handshake. While the mode input is low the block neither accepts words nor requests. The acknowledge passes through a two-flop synchronizer. A three-state machine sequences every transfer. IDLE offers `src_ready`. The transition IDLE→ARMED fires on a source handshake and latches the word. The transition ARMED→DRIVE fires once the synchronized acknowledge is low: it loads the bus, enables it and clears the hold timer. The transition DRIVE→IDLE fires once the hold timer is done and the synchronized acknowledge is high. Every other case keeps the current state.

Top module: `dma_rd_responder`

## Requirements
- R1: After reset, `dma_req_n` is 1, `bus_oe` is 0 and no word is held.
- R2: While `async_en` is 0, `src_ready` stays 0, `dma_req_n` stays 1 and `bus_oe` stays 0, whatever `src_valid` does.
- R3: In IDLE with `async_en` high, `src_ready` is 1. A clock edge with `src_valid` and `src_ready` both high latches `src_data`, and `dma_req_n` is 0 and `src_ready` is 0 in the following cycle.
- R4: An acknowledge that falls between two rising edges is first seen on the second edge after the fall. On the third edge after the fall, `bus_oe` becomes 1, `bus_data` carries the latched word and `dma_req_n` becomes 1.
- R5: For an acknowledge pulse shorter than the minimum hold time, `bus_oe` stays 1 for exactly HOLD_MIN+1 cycles. This is 3 cycles by default.
- R6: While the synchronized acknowledge is low, the bus stays driven. For an acknowledge held low for L cycles, `bus_oe` stays 1 for max(HOLD_MIN+1, L) cycles.
- R7: `bus_data` does not change while `bus_oe` stays 1.
- R8: `dma_req_n` is never 0 while `bus_oe` is 1. The request is raised again only after release, once a new word has been taken.
- R9: Back-to-back transfers each deliver their own word, in the order the words were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| async_en | input | 1 | Enables the asynchronous handshake |
| dma_ack_n | input | 1 | Active-low acknowledge, asynchronous to clk |
| dma_req_n | output | 1 | Active-low request |
| bus_data | output | 16 | Data driven to the bus |
| bus_oe | output | 1 | Bus drive enable |
| src_valid | input | 1 | Source offers a word |
| src_data | input | 16 | Offered word |
| src_ready | output | 1 | Block takes the offered word |

## Verification
The assertions assume that the acknowledge falls only while the request is active, and that it returns high before the next request is answered. They also assume that `async_en` does not drop in the middle of a transfer. The driver changes the acknowledge only on falling clock edges, and only after it has seen `dma_req_n` low. It then waits until the bus is released and the acknowledge is high before it offers the next word. For that reason the synchronizer latency, and with it the exact drive window, is known to the cycle.

// File: rtl/dma_rd_pkg.sv
package dma_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_DRIVE = 2'd2
    } rd_state_e;
endpackage

// File: rtl/ack_sync.sv
module ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b1;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
    parameter int HOLD_MIN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(HOLD_MIN + 1) + 1;
    logic [CW-1:0] cnt_q;

    assign done = (cnt_q == CW'(HOLD_MIN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (clear)       cnt_q <= '0;
        else if (run && !done) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dma_rd_responder.sv
module dma_rd_responder
    import dma_rd_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_MIN    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              async_en,
    input  logic              dma_ack_n,
    output logic              dma_req_n,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_oe,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready
);
    rd_state_e   state_q, state_d;
    logic        ack_s;
    logic        ack_lo;
    logic        hold_done;
    logic        take_word, start_drive, release_bus;
    logic [DATA_W-1:0] word_q;

    ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(dma_ack_n), .sync_out(ack_s)
    );
    assign ack_lo = ~ack_s;

    hold_timer #(.HOLD_MIN(HOLD_MIN)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .clear(start_drive), .run(state_q == ST_DRIVE), .done(hold_done)
    );

    assign src_ready   = (state_q == ST_IDLE) && async_en;
    assign take_word   = src_ready && src_valid;
    assign start_drive = (state_q == ST_ARMED) && ack_lo;
    assign release_bus = (state_q == ST_DRIVE) && hold_done && !ack_lo;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_word)   state_d = ST_ARMED;
            ST_ARMED: if (start_drive) state_d = ST_DRIVE;
            ST_DRIVE: if (release_bus) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            bus_data  <= '0;
            bus_oe    <= 1'b0;
            dma_req_n <= 1'b1;
        end else begin
            if (take_word) begin
                word_q    <= src_data;
                dma_req_n <= 1'b0;
            end
            if (start_drive) begin
                bus_data  <= word_q;
                bus_oe    <= 1'b1;
                dma_req_n <= 1'b1;
            end
            if (release_bus) bus_oe <= 1'b0;
        end
    end

    AST_OE_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> dma_req_n); // R8
    AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_data)); // R7
    AST_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_oe) |-> $past(hold_done)); // R5
    AST_HOLD_WHILE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && ack_lo) |=> bus_oe); // R6
    AST_REQ_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_req_n) |-> $past(async_en)); // R2
endmodule

// File: tb/dma_rd_responder_test.sv
module dma_rd_responder_test;
    localparam int HMIN = 2;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        async_en = 0;
    logic        dma_ack_n = 1;
    logic        dma_req_n;
    logic [15:0] bus_data;
    logic        bus_oe;
    logic        src_valid = 0;
    logic [15:0] src_data = '0;
    logic        src_ready;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done_flag = 0;

    typedef struct { logic [15:0] data; int dur; } exp_t;
    exp_t exp_q[$];

    dma_rd_responder #(.HOLD_MIN(HMIN)) uut (
        .clk(clk), .rst_n(rst_n), .async_en(async_en), .dma_ack_n(dma_ack_n),
        .dma_req_n(dma_req_n), .bus_data(bus_data), .bus_oe(bus_oe),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Monitor: compares each drive window against the scoreboard queue
    int         run = 0;
    logic [15:0] cur;
    exp_t       head;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_oe) begin
                chk("R8 req_n high while driving", dma_req_n, 1);
                if (run == 0) begin
                    if (exp_q.size() == 0) chk("R9 unexpected drive", 1, 0);
                    else begin
                        head = exp_q[0];
                        chk("R9 word order", bus_data, head.data);
                    end
                    cur = bus_data;
                end else begin
                    chk("R7 data stable", bus_data, cur);
                end
                run++;
            end else if (run > 0) begin
                if (exp_q.size() > 0) begin
                    head = exp_q.pop_front();
                    chk(head.dur > HMIN + 1 ? "R6 drive length" : "R5 drive length",
                        run, head.dur);
                end
                run = 0;
            end
        end
    end

    // Driver: one transfer with an acknowledge low for lo cycles
    task automatic xfer(input logic [15:0] d, input int lo);
        exp_t e;
        int   span;
        @(negedge clk);
        src_valid = 1;
        src_data  = d;
        while (!src_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        src_valid = 0;
        chk("R3 request after take", dma_req_n, 0);
        chk("R3 ready drops", src_ready, 0);
        e.data = d;
        e.dur  = (lo > HMIN + 1) ? lo : HMIN + 1;
        exp_q.push_back(e);
        dma_ack_n = 0;
        span = (lo > 4) ? lo : 4;
        for (int i = 1; i <= span; i++) begin
            @(negedge clk);
            if (i == lo) dma_ack_n = 1;
            if (i == 2) chk("R4 not yet driven", bus_oe, 0);
            if (i == 3) begin
                chk("R4 driven on third edge", bus_oe, 1);
                chk("R4 data", bus_data, d);
            end
        end
        while (bus_oe) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req_n", dma_req_n, 1);
        chk("R1 oe", bus_oe, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 req_n after reset", dma_req_n, 1);
        // mode off: offered words are ignored
        src_valid = 1;
        src_data  = 16'hDEAD;
        repeat (6) begin
            @(negedge clk);
            chk("R2 ready", src_ready, 0);
            chk("R2 req_n", dma_req_n, 1);
            chk("R2 oe", bus_oe, 0);
        end
        src_valid = 0;
        async_en  = 1;
        @(negedge clk);
        chk("R3 ready in idle", src_ready, 1);
        xfer(16'h1234, 1);
        xfer(16'hABCD, 2);
        xfer(16'h0F0F, 3);
        xfer(16'h5A5A, 6);
        xfer(16'hFFFF, 10);
        xfer(16'h0001, 1);
        xfer(16'h8000, 4);
        repeat (4) @(negedge clk);
        chk("R9 scoreboard drained", exp_q.size(), 0);
        done_flag = 1;
    end

    always @(posedge clk) begin
        cycles++;
        if (done_flag || cycles > 20000) begin
            if (!done_flag) begin
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule